// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a 1 KB data cache that sits between a processor load/store port and a slower word-wide memory port. It holds 32 lines of 32 bytes each. Every line has one possible home, chosen by address bits, so no replacement choice is ever needed. The processor issues one request at a time. A hit answers in the cycle right after the lookup. A miss stalls the port while the cache moves whole blocks to and from memory.

Stores stay in the cache and set the line's dirty flag. Memory sees a modified line only when that line is evicted. Eviction and refill run as sequences of eight one-word beats on a valid/ready handshake. Beats go in ascending address order. The dirty victim is always drained completely before the first beat of the new block is requested. A store miss first allocates the line by refilling it, then merges the store bytes into it.

Top module: `dm_wb_cache`

## Requirements
- R1: A 32-bit byte address splits into tag = bits 31..10, line index = bits 9..5 and word-in-block = bits 4..2. Bits 1..0 never change which word is read.
- R2: After reset every line is invalid, `cpu_req_ready` is 1, and `cpu_rsp_valid` and `mem_valid` are 0. The first access to any block is a miss.
- R3: A read hit accepted on clock edge k raises `cpu_rsp_valid` for the cycle after edge k+1, returns the stored word, and produces no memory beat.
- R4: A read miss on a clean or empty line issues eight read beats (`mem_write`=0). The beats go to the block base + 4*i for i = 0..7, in that order. The response then carries the requested word of the new block.
- R5: A write hit updates only the bytes whose `cpu_req_be` bit is 1 (bit j covers data bits 8j+7..8j), marks the line dirty, produces no memory beat, and responds with the same latency as a read hit.
- R6: A write miss refills the whole block first, then merges the store bytes under the byte enables, and leaves the line dirty.
- R7: A miss on a dirty line first writes all eight words of the old block (`mem_write`=1), at addresses built from the old tag, ascending. Only then does it issue any read beat of the new block.
- R8: A miss that evicts a clean line issues no write beat.
- R9: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` hold their values.
- R10: `cpu_req_ready` is 0 from the acceptance edge until the response cycle has ended. `cpu_rsp_valid` lasts exactly one cycle.
- R11: Two addresses with the same index and different tags evict each other, and each access after the other misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_req_be | input | 4 | Store byte enables |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_rsp_valid | output | 1 | One-cycle response strobe |
| cpu_rsp_rdata | output | 32 | Load data, valid with the strobe |
| mem_valid | output | 1 | Memory beat requested |
| mem_write | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr | output | 32 | Word-aligned beat address |
| mem_wdata | output | 32 | Write-back beat data |
| mem_ready | input | 1 | Memory takes the beat this cycle |
| mem_rdata | input | 32 | Refill beat data, valid with `mem_ready` |

## Verification
The bench targets these corner cases:
- A dirty line evicted by a same-index conflict. A cache that skipped the write-back, or refilled before draining, would lose the store or reorder beats against the expected sequence.
- A store merged under sparse byte enables right after a write-miss refill. A wrong merge order would either overwrite the fill or be overwritten by it.
- Memory stalls in the middle of a block, which expose any beat that drops its address or skips a word.
- A victim that is clean. Here any write beat at all is an error.
- Low address bits that must not change the selected word.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_COMPARE   = 3'd1,
    ST_WRITEBACK = 3'd2,
    ST_REFILL    = 3'd3,
    ST_RESPOND   = 3'd4
  } cache_state_e;

endpackage

// File: rtl/cache_rst_sync.sv
module cache_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int NUM_LINES = 32,
  parameter int TAG_W     = 22,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic             line_valid,
  output logic             line_dirty,
  output logic [TAG_W-1:0] line_tag,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             mark_dirty
);

  logic [NUM_LINES-1:0] valid_q;
  logic [NUM_LINES-1:0] dirty_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];

  // flags need a known state after reset; tags are qualified by valid
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_en) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end else if (mark_dirty) begin
        dirty_q[idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx] <= fill_tag;
  end

  assign line_valid = valid_q[idx];
  assign line_dirty = dirty_q[idx];
  assign line_tag   = tag_q[idx];

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int NUM_LINES  = 32,
  parameter int BEATS      = 8,
  parameter int WORD_W     = 32,
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int BEAT_W    = $clog2(BEATS),
  localparam int WORD_BYTES = WORD_W / 8
) (
  input  logic                  clk,
  input  logic [IDX_W-1:0]      line,
  input  logic [BEAT_W-1:0]     rd_beat,
  output logic [WORD_W-1:0]     rd_word,
  input  logic                  wr_en,
  input  logic [BEAT_W-1:0]     wr_beat,
  input  logic [WORD_BYTES-1:0] wr_be,
  input  logic [WORD_W-1:0]     wr_word
);

  logic [WORD_W-1:0] words_q [NUM_LINES*BEATS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < WORD_BYTES; b++) begin
        if (wr_be[b]) words_q[{line, wr_beat}][b*8 +: 8] <= wr_word[b*8 +: 8];
      end
    end
  end

  assign rd_word = words_q[{line, rd_beat}];

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 32,
  localparam int WORD_BYTES = WORD_W / 8,
  localparam int BEATS      = LINE_BYTES / WORD_BYTES,
  localparam int BSEL_W     = $clog2(WORD_BYTES),
  localparam int OFFS_W     = $clog2(LINE_BYTES),
  localparam int IDX_W      = $clog2(NUM_LINES),
  localparam int BEAT_W     = $clog2(BEATS),
  localparam int TAG_LO     = OFFS_W + IDX_W,
  localparam int TAG_W      = ADDR_W - TAG_LO
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_req_valid,
  input  logic                  cpu_req_write,
  input  logic [ADDR_W-1:0]     cpu_req_addr,
  input  logic [WORD_W-1:0]     cpu_req_wdata,
  input  logic [WORD_BYTES-1:0] cpu_req_be,
  output logic                  cpu_req_ready,
  output logic                  cpu_rsp_valid,
  output logic [WORD_W-1:0]     cpu_rsp_rdata,
  output logic                  mem_valid,
  output logic                  mem_write,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [WORD_W-1:0]     mem_wdata,
  input  logic                  mem_ready,
  input  logic [WORD_W-1:0]     mem_rdata,
  output logic [IDX_W-1:0]      ts_idx,
  input  logic                  ts_valid,
  input  logic                  ts_dirty,
  input  logic [TAG_W-1:0]      ts_tag,
  output logic                  ts_fill_en,
  output logic [TAG_W-1:0]      ts_fill_tag,
  output logic                  ts_mark_dirty,
  output logic [BEAT_W-1:0]     ds_rd_beat,
  input  logic [WORD_W-1:0]     ds_rd_word,
  output logic                  ds_wr_en,
  output logic [BEAT_W-1:0]     ds_wr_beat,
  output logic [WORD_BYTES-1:0] ds_wr_be,
  output logic [WORD_W-1:0]     ds_wr_word,
  output cache_state_e          state
);

  cache_state_e state_q, state_d;
  logic [BEAT_W-1:0]     beat_q, beat_d;
  logic [ADDR_W-1:0]     addr_q;
  logic                  wr_q;
  logic [WORD_W-1:0]     wdata_q;
  logic [WORD_BYTES-1:0] be_q;
  logic [WORD_W-1:0]     rdata_q;

  logic             accept, hit, beat_go, beat_last, beat_en, req_en, rdata_en;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic [BEAT_W-1:0] req_beat;

  assign req_idx  = addr_q[TAG_LO-1:OFFS_W];
  assign req_tag  = addr_q[ADDR_W-1:TAG_LO];
  assign req_beat = addr_q[OFFS_W-1:BSEL_W];

  assign accept    = (state_q == ST_IDLE) && cpu_req_valid;
  assign hit       = ts_valid && (ts_tag == req_tag);
  assign beat_go   = mem_valid && mem_ready;
  assign beat_last = (beat_q == BEAT_W'(BEATS-1));

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (accept) state_d = ST_COMPARE;
      ST_COMPARE: begin
        if (hit)                       state_d = ST_RESPOND;
        else if (ts_valid && ts_dirty) state_d = ST_WRITEBACK;
        else                           state_d = ST_REFILL;
      end
      ST_WRITEBACK: if (beat_go && beat_last) state_d = ST_REFILL;
      ST_REFILL:    if (beat_go && beat_last) state_d = ST_COMPARE;
      ST_RESPOND:   state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  assign beat_en  = beat_go;
  assign beat_d   = beat_last ? '0 : beat_q + 1'b1;
  assign req_en   = accept;
  assign rdata_en = (state_q == ST_COMPARE) && hit;

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (beat_en) beat_q <= beat_d;
    end
  end

  // datapath registers, enabled only
  always_ff @(posedge clk) begin
    if (req_en) begin
      addr_q  <= cpu_req_addr;
      wr_q    <= cpu_req_write;
      wdata_q <= cpu_req_wdata;
      be_q    <= cpu_req_be;
    end
    if (rdata_en) rdata_q <= ds_rd_word;
  end

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign cpu_rsp_valid = (state_q == ST_RESPOND);
  assign cpu_rsp_rdata = rdata_q;

  assign mem_valid = (state_q == ST_WRITEBACK) || (state_q == ST_REFILL);
  assign mem_write = (state_q == ST_WRITEBACK);
  assign mem_addr  = {(mem_write ? ts_tag : req_tag), req_idx, beat_q, BSEL_W'(0)};
  assign mem_wdata = ds_rd_word;

  assign ts_idx        = req_idx;
  assign ts_fill_en    = (state_q == ST_REFILL) && beat_go && beat_last;
  assign ts_fill_tag   = req_tag;
  assign ts_mark_dirty = (state_q == ST_COMPARE) && hit && wr_q;

  assign ds_rd_beat = (state_q == ST_WRITEBACK) ? beat_q : req_beat;
  assign ds_wr_en   = ((state_q == ST_REFILL) && beat_go) || ts_mark_dirty;
  assign ds_wr_beat = (state_q == ST_REFILL) ? beat_q : req_beat;
  assign ds_wr_be   = (state_q == ST_REFILL) ? '1 : be_q;
  assign ds_wr_word = (state_q == ST_REFILL) ? mem_rdata : wdata_q;

  assign state = state_q;

endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 32,
  localparam int WORD_BYTES = WORD_W / 8,
  localparam int BEATS      = LINE_BYTES / WORD_BYTES,
  localparam int OFFS_W     = $clog2(LINE_BYTES),
  localparam int IDX_W      = $clog2(NUM_LINES),
  localparam int BEAT_W     = $clog2(BEATS),
  localparam int TAG_W      = ADDR_W - OFFS_W - IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_req_valid,
  input  logic                  cpu_req_write,
  input  logic [ADDR_W-1:0]     cpu_req_addr,
  input  logic [WORD_W-1:0]     cpu_req_wdata,
  input  logic [WORD_BYTES-1:0] cpu_req_be,
  output logic                  cpu_req_ready,
  output logic                  cpu_rsp_valid,
  output logic [WORD_W-1:0]     cpu_rsp_rdata,
  output logic                  mem_valid,
  output logic                  mem_write,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [WORD_W-1:0]     mem_wdata,
  input  logic                  mem_ready,
  input  logic [WORD_W-1:0]     mem_rdata
);

  logic                  rst_n_int;
  logic [IDX_W-1:0]      ts_idx;
  logic                  ts_valid, ts_dirty, ts_fill_en, ts_mark_dirty;
  logic [TAG_W-1:0]      ts_tag, ts_fill_tag;
  logic [BEAT_W-1:0]     ds_rd_beat, ds_wr_beat;
  logic [WORD_W-1:0]     ds_rd_word, ds_wr_word;
  logic                  ds_wr_en;
  logic [WORD_BYTES-1:0] ds_wr_be;
  cache_state_e          state;

  cache_rst_sync u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  cache_tag_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n_int), .idx(ts_idx),
    .line_valid(ts_valid), .line_dirty(ts_dirty), .line_tag(ts_tag),
    .fill_en(ts_fill_en), .fill_tag(ts_fill_tag), .mark_dirty(ts_mark_dirty)
  );

  cache_data_store #(.NUM_LINES(NUM_LINES), .BEATS(BEATS), .WORD_W(WORD_W)) u_data (
    .clk(clk), .line(ts_idx), .rd_beat(ds_rd_beat), .rd_word(ds_rd_word),
    .wr_en(ds_wr_en), .wr_beat(ds_wr_beat), .wr_be(ds_wr_be), .wr_word(ds_wr_word)
  );

  cache_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_BYTES(LINE_BYTES), .NUM_LINES(NUM_LINES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n_int),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata), .cpu_req_be(cpu_req_be),
    .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .ts_idx(ts_idx), .ts_valid(ts_valid), .ts_dirty(ts_dirty), .ts_tag(ts_tag),
    .ts_fill_en(ts_fill_en), .ts_fill_tag(ts_fill_tag), .ts_mark_dirty(ts_mark_dirty),
    .ds_rd_beat(ds_rd_beat), .ds_rd_word(ds_rd_word), .ds_wr_en(ds_wr_en),
    .ds_wr_beat(ds_wr_beat), .ds_wr_be(ds_wr_be), .ds_wr_word(ds_wr_word),
    .state(state)
  );

endmodule

// File: rtl/cache_sva.sv
module cache_sva
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 32,
  localparam int WORD_BYTES = WORD_W / 8,
  localparam int BSEL_W     = $clog2(WORD_BYTES),
  localparam int OFFS_W     = $clog2(LINE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              mem_valid,
  input logic              mem_write,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input cache_state_e      state
);

  logic last_word;
  assign last_word = (mem_addr[OFFS_W-1:BSEL_W] == '1);

  assert_rsp_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);

  assert_stall_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

  assert_no_accept_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_req_ready && (cpu_rsp_valid || mem_valid)));

  assert_beat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_write) && $stable(mem_wdata)));

  assert_beat_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !last_word) |=>
      (mem_valid && $stable(mem_write) &&
       mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES)));

  assert_drain_before_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_write && last_word) |=>
      (mem_valid && !mem_write && mem_addr[OFFS_W-1:0] == '0));

  assert_respond_after_compare_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rsp_valid) |-> $past(state) == ST_COMPARE);

endmodule

bind dm_wb_cache cache_sva #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_BYTES(LINE_BYTES)
) u_cache_sva (
  .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_rsp_valid(cpu_rsp_valid), .mem_valid(mem_valid), .mem_write(mem_write),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .state(state)
);

// File: tb/dm_wb_cache_bench.sv
module dm_wb_cache_bench;

  logic        clk;
  logic        rst_n;
  logic        cpu_req_valid, cpu_req_write;
  logic [31:0] cpu_req_addr, cpu_req_wdata;
  logic [3:0]  cpu_req_be;
  logic        cpu_req_ready, cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        mem_valid, mem_write;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready;
  logic [31:0] mem_rdata;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit mon_on = 0;

  dm_wb_cache u_dm_wb_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata), .cpu_req_be(cpu_req_be),
    .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- reference model ----------------
  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;
  } beat_t;

  beat_t       expq[$];
  logic [31:0] bmem [logic [31:0]];
  bit          rv    [32];
  bit          rdirty[32];
  logic [21:0] rtag  [32];
  logic [31:0] rdat  [32][8];

  function automatic logic [31:0] backing(logic [31:0] a);
    if (bmem.exists(a)) return bmem[a];
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // memory responder and beat monitor
  logic [31:0] stall_addr;
  bit          stalled = 0;
  int          ready_cnt = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      ready_cnt++;
      mem_ready = (ready_cnt % 5 != 2) && (ready_cnt % 7 != 3);
      mem_rdata = backing(mem_addr);
      if (stalled)
        check(mem_valid && mem_addr == stall_addr, "R9", "beat held during stall",
              mem_addr, stall_addr);
      stalled    = mem_valid && !mem_ready;
      stall_addr = mem_addr;
      if (mem_valid && mem_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R8", "unexpected memory beat", mem_addr, 32'h0);
        end else begin
          check(mem_write == expq[0].wr && mem_addr == expq[0].addr,
                expq[0].wr ? "R7" : "R4", "beat kind/address",
                {mem_write, mem_addr[30:0]}, {expq[0].wr, expq[0].addr[30:0]});
          if (expq[0].wr)
            check(mem_wdata == expq[0].data, "R7", "write-back data", mem_wdata, expq[0].data);
          void'(expq.pop_front());
        end
      end
    end
  end

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input string rq);
    logic [4:0]  idx;
    logic [21:0] tg;
    logic [2:0]  w;
    bit          hit;
    logic [31:0] expd;
    int          cnt;
    idx = a[9:5];
    tg  = a[31:10];
    w   = a[4:2];
    hit = rv[idx] && rtag[idx] == tg;
    if (!hit) begin
      if (rv[idx] && rdirty[idx]) begin
        for (int i = 0; i < 8; i++) begin
          logic [31:0] va;
          va = {rtag[idx], idx, 3'(i), 2'b00};
          expq.push_back('{1'b1, va, rdat[idx][i]});
          bmem[va] = rdat[idx][i];
        end
      end
      for (int i = 0; i < 8; i++) begin
        logic [31:0] na;
        na = {tg, idx, 3'(i), 2'b00};
        expq.push_back('{1'b0, na, backing(na)});
        rdat[idx][i] = backing(na);
      end
      rv[idx] = 1; rtag[idx] = tg; rdirty[idx] = 0;
    end
    expd = rdat[idx][w];
    if (wr) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) rdat[idx][w][b*8 +: 8] = wd[b*8 +: 8];
      rdirty[idx] = 1;
    end
    cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = a;
    cpu_req_wdata = wd; cpu_req_be = be;
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 0;
    check(!cpu_req_ready, "R10", "ready low after accept", {31'd0, cpu_req_ready}, 32'd0);
    cnt = 1;
    while (!cpu_rsp_valid && cnt < 300) begin
      @(negedge clk);
      cnt++;
    end
    check(cpu_rsp_valid, rq, "response seen", {31'd0, cpu_rsp_valid}, 32'd1);
    if (hit) check(cnt == 2, rq, "hit latency", cnt, 32'd2);
    if (!wr) check(cpu_rsp_rdata == expd, rq, "read data", cpu_rsp_rdata, expd);
    check(expq.size() == 0, rq, "all beats done before response", expq.size(), 32'd0);
    @(negedge clk);
    check(!cpu_rsp_valid && cpu_req_ready, "R10", "single-cycle response",
          {30'd0, cpu_rsp_valid, cpu_req_ready}, 32'd1);
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    cpu_req_valid = 0; cpu_req_write = 0; cpu_req_addr = '0;
    cpu_req_wdata = '0; cpu_req_be = '0;
    mem_ready = 0; mem_rdata = '0;
    for (int i = 0; i < 32; i++) begin rv[i] = 0; rdirty[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(cpu_req_ready && !cpu_rsp_valid && !mem_valid, "R2", "reset state",
          {29'd0, cpu_req_ready, cpu_rsp_valid, mem_valid}, 32'd4);
    mon_on = 1;
    @(negedge clk);

    access(0, 32'h0000_1234, '0, '0, "R2");      // cold miss
    access(0, 32'h0000_1238, '0, '0, "R3");      // hit, other word
    access(1, 32'h0000_1230, 32'hDEAD_BEEF, 4'b0101, "R5");
    access(0, 32'h0000_1230, '0, '0, "R5");
    access(0, 32'h0000_1233, '0, '0, "R1");      // low bits ignored
    access(0, 32'h0000_1210, '0, '0, "R1");      // bit 5 clear: other line
    access(0, 32'h0004_1230, '0, '0, "R11");     // conflict, dirty victim
    access(0, 32'h0000_1230, '0, '0, "R8");      // clean victim
    access(0, 32'h0004_1230, '0, '0, "R11");
    access(1, 32'h0000_2344, 32'h1122_3344, 4'b1001, "R6"); // write miss
    access(0, 32'h0000_2344, '0, '0, "R6");
    access(0, 32'h0008_2344, '0, '0, "R7");      // evicts merged line
    access(0, 32'h0000_2344, '0, '0, "R4");

    for (int n = 0; n < 80; n++) begin
      logic [31:0] ra;
      logic [3:0]  rb;
      ra = {20'd0, 2'($urandom_range(0, 3)), 5'($urandom_range(0, 2)), 3'($urandom), 2'b00};
      rb = 4'($urandom_range(1, 15));
      access(1'($urandom), ra, $urandom, rb, "R7");
    end

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule